// File: doc/BRIEF.md
# Register-Mapped SPI Controller

This block is an SPI port with three byte-wide registers on a simple synchronous bus: control, status and data. In master mode it makes the serial clock from the system clock through a selectable divider. A write to the data register loads the shifter and starts a byte transfer on the same write, with no separate start command. In slave mode it shifts on an external serial clock while its active-low select input is low. That clock, the select input and the slave data input all pass through a two-stage synchronizer.

Bit order, clock polarity and clock phase are programmable. A done flag and a collision flag are held in the status register, and an interrupt line reports the done flag. Software clears both flags by reading the status register while a flag is set and then accessing the data register. The controller never drives any chip select in master mode; software owns it.

Top module: `spi_regctl`

## Requirements
- R1: After reset, the control, status and data registers read 0x00, and `irq`, `sck_o`, `mosi_o` and `miso_o` are 0.
- R2: The control register is at address 0 and reads back as written. Its fields are: bit 7 interrupt enable, bit 6 enable, bit 5 LSB-first, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate select.
- R3: The status register is at address 1. Bit 7 is the done flag, bit 6 is the collision flag and bit 0 is the double-speed bit, which is the only writable bit. Bits 5:1 read 0. The data register is at address 2. Read data is valid in the cycle after `bus_rd`.
- R4: In master mode with enable set, a data write at clock edge E starts a transfer. `sck_o` toggles at edges E+k·H for k = 1..16, where H is half the divider, and rests at the polarity bit when idle. The select input has no effect in master mode.
- R5: Rate select 00/01/10/11 gives a divider of 4/16/64/128. Setting the double-speed bit halves it.
- R6: With phase 0, each bit is on the data output before the leading edge, is sampled on the leading edge and changes on the trailing edge. With phase 1, the data output changes on the leading edge and is sampled on the trailing edge. The leading edge is rising when polarity is 0 and falling when polarity is 1.
- R7: With the LSB-first bit at 1, bit 0 goes first on the wire. With it at 0, bit 7 goes first. The same order applies to received bits.
- R8: Reading the data register returns the last fully received byte.
- R9: The done flag sets after the 16th master clock edge, or after the 8th slave sample. `irq` is high exactly when the done flag and the interrupt enable are both 1.
- R10: A data write during a transfer sets the collision flag. The shifter keeps its byte and the transfer goes on unchanged.
- R11: A data register access clears both flags only when it follows a status read that saw a flag set. A data access without that status read leaves the flags as they are.
- R12: In slave mode, serial clock edges shift data only while the select input is low. Edges seen while it is high change neither the flags nor the received byte, and `miso_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock in |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |

## Verification
The hardest state to reach is a data write that lands in the middle of a running master transfer. It must raise the collision flag but must not disturb a single bit on the wire. The bench reaches it by issuing that write at a chosen cycle inside its cycle-counted transfer loop. It then keeps comparing the data output against the original byte on every clock. The two-step flag clear is also awkward: the bench first touches the data register without a status read to show the flags survive, and only then runs the proper sequence.

// File: rtl/spi_regctl_pkg.sv
package spi_regctl_pkg;
  localparam int HALF_W = 7;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctl_t;

  // half of the SCK period, in system clocks
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
    logic [HALF_W-1:0] h;
    case (rate)
      2'd0:    h = HALF_W'(2);
      2'd1:    h = HALF_W'(8);
      2'd2:    h = HALF_W'(32);
      default: h = HALF_W'(64);
    endcase
    return dbl ? (h >> 1) : h;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= RST_VAL;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = run && (cnt == half - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < half)); // R5
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          clr,
  input  logic          lead,
  input  logic          trail,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          din,
  output logic          dout,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_next
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] tx, rx;
  logic [CW-1:0] nsmp;
  logic is_smp, is_sft;

  assign is_smp  = cpha ? trail : lead;
  assign is_sft  = cpha ? lead  : trail;
  assign rx_next = lsb_first ? {din, rx[DW-1:1]} : {rx[DW-2:0], din};
  assign done    = is_smp && (nsmp == CW'(DW-1));
  assign dout    = lsb_first ? tx[0] : tx[DW-1];
  assign busy    = (nsmp != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx   <= '0;
      rx   <= '0;
      nsmp <= '0;
    end else begin
      if (load)
        tx <= ld_data;
      else if (is_sft && busy)
        tx <= lsb_first ? (tx >> 1) : (tx << 1);
      if (load || clr) begin
        nsmp <= '0;
      end else if (is_smp) begin
        rx   <= rx_next;
        nsmp <= done ? '0 : nsmp + CW'(1);
      end
    end
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    load |=> !busy); // R10
endmodule

// File: rtl/spi_regctl.sv
module spi_regctl
  import spi_regctl_pkg::*;
#(
  parameter int DW      = 8,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sck_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  output logic          miso_o
);
  localparam int EW = $clog2(2*DW) + 1;

  ctl_t ctl;
  logic dbl, spif, wcol, armed, m_active, sck_q, sck_d;
  logic [EW-1:0] m_edges;
  logic [DW-1:0] rx_buf, rx_next;
  logic sck_s, ssn_s, mosi_s;
  logic [HALF_W-1:0] half;
  logic tick, m_lead, m_trail, m_done;
  logic sel, s_rise, s_fall, s_lead, s_trail;
  logic wr_data, data_acc, busy, coll, load, start;
  logic core_dout, core_busy, core_done;

  spi_sync #(.W(3), .STAGES(SYNC_ST), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sck_i, ss_n_i, mosi_i}), .q({sck_s, ssn_s, mosi_s}));

  assign half = half_period(ctl.rate, dbl);

  spi_rate_gen #(.HALF_W(HALF_W)) u_rate (
    .clk(clk), .rst(rst), .run(m_active), .half(half), .tick(tick));

  // master edge classification: odd-numbered edge is the leading one
  assign m_lead  = tick && !m_edges[0];
  assign m_trail = tick &&  m_edges[0];
  assign m_done  = tick && (m_edges == EW'(2*DW-1));

  // slave edge detection on synchronized clock
  assign sel     = ctl.en && !ctl.master && !ssn_s;
  assign s_rise  =  sck_s && !sck_d;
  assign s_fall  = !sck_s &&  sck_d;
  assign s_lead  = sel && (ctl.cpol ? s_fall : s_rise);
  assign s_trail = sel && (ctl.cpol ? s_rise : s_fall);

  assign wr_data  = bus_wr && (bus_addr == ADR_DATA);
  assign data_acc = (bus_wr || bus_rd) && (bus_addr == ADR_DATA);
  assign busy     = m_active || (!ctl.master && core_busy);
  assign coll     = wr_data && busy;
  assign load     = wr_data && !busy;
  assign start    = load && ctl.en && ctl.master;

  spi_shift_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .load(load), .ld_data(bus_wdata),
    .clr(ctl.master ? 1'b0 : !sel),
    .lead(ctl.master ? m_lead : s_lead),
    .trail(ctl.master ? m_trail : s_trail),
    .cpha(ctl.cpha), .lsb_first(ctl.lsb_first),
    .din(ctl.master ? miso_i : mosi_s),
    .dout(core_dout), .busy(core_busy), .done(core_done), .rx_next(rx_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      dbl       <= 1'b0;
      spif      <= 1'b0;
      wcol      <= 1'b0;
      armed     <= 1'b0;
      m_active  <= 1'b0;
      m_edges   <= '0;
      sck_q     <= 1'b0;
      sck_d     <= 1'b0;
      rx_buf    <= '0;
      bus_rdata <= '0;
    end else begin
      sck_d <= sck_s;
      if (bus_wr && bus_addr == ADR_CTRL) ctl <= ctl_t'(bus_wdata);
      if (bus_wr && bus_addr == ADR_STAT) dbl <= bus_wdata[0];

      if (start) begin
        m_active <= 1'b1;
        m_edges  <= '0;
      end else if (tick) begin
        m_edges <= m_edges + EW'(1);
        if (m_done) m_active <= 1'b0;
      end

      if (!m_active) sck_q <= ctl.cpol;
      else if (tick) sck_q <= !sck_q;

      if (core_done) rx_buf <= rx_next;

      if (ctl.master ? m_done : core_done) spif <= 1'b1;
      else if (data_acc && armed)          spif <= 1'b0;
      if (coll)                            wcol <= 1'b1;
      else if (data_acc && armed)          wcol <= 1'b0;

      if (data_acc) armed <= 1'b0;
      else if (bus_rd && bus_addr == ADR_STAT && (spif || wcol)) armed <= 1'b1;

      if (bus_rd) begin
        case (bus_addr)
          ADR_CTRL: bus_rdata <= ctl;
          ADR_STAT: bus_rdata <= {spif, wcol, 5'b0, dbl};
          ADR_DATA: bus_rdata <= rx_buf;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  assign irq    = ctl.irq_en && spif;
  assign sck_o  = sck_q;
  assign mosi_o = ctl.master ? core_dout : 1'b0;
  assign miso_o = sel ? core_dout : 1'b0;

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !m_active |=> (sck_o == $past(ctl.cpol))); // R4
  AST_START_NOW: assert property (@(posedge clk) disable iff (rst)
    start |=> m_active); // R4
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (m_active && m_done) |=> spif); // R9
  AST_COLL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_data && busy) |=> wcol); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_STAT) |=> (bus_rdata[5:1] == 5'b0)); // R3
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ssn_s |-> !miso_o); // R12
endmodule

// File: tb/spi_regctl_bench.sv
module spi_regctl_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sck_o, mosi_o, miso_o;
  logic miso_i = 0, sck_i = 0, ss_n_i = 1, mosi_i = 0;
  int nrun = 0, nfail = 0;
  logic cur_dbl = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_regctl u_spi_regctl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i), .ss_n_i(ss_n_i),
    .mosi_i(mosi_i), .miso_o(miso_o));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic bit_of(input logic [7:0] b, input int i, input logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  // master transfer with a per-clock reference of the wire and irq
  task automatic master_xfer(input logic [7:0] ctl, input logic dbl, input logic [7:0] txb,
                             input logic [7:0] slvb, input int coll_at, input logic early_rd);
    int base[4] = '{2, 8, 32, 64};
    int half, ticks, idx;
    logic cpol, cpha, lsb, ie;
    logic [7:0] r;
    cpol = ctl[3]; cpha = ctl[2]; lsb = ctl[5]; ie = ctl[7];
    half = dbl ? base[ctl[1:0]] / 2 : base[ctl[1:0]];
    wr(2'd0, ctl);
    wr(2'd1, {7'b0, dbl});
    cur_dbl = dbl;
    bus_addr = 2'd2; bus_wdata = txb; bus_wr = 1;
    miso_i = cpha ? 1'b0 : bit_of(slvb, 0, lsb);
    @(negedge clk);
    bus_wr = 0;
    for (int m = 0; m <= 16*half + 2; m++) begin
      ticks = (m / half > 16) ? 16 : m / half;
      if (m == coll_at) begin bus_addr = 2'd2; bus_wdata = ~txb; bus_wr = 1; end
      if (m == coll_at + 1) bus_wr = 0;
      chk(sck_o == (cpol ^ ticks[0]), "R4/R5 sck", sck_o, cpol ^ ticks[0]);
      if (!cpha && ticks < 16)
        chk(mosi_o == bit_of(txb, ticks/2, lsb), "R6/R7 mosi", mosi_o, bit_of(txb, ticks/2, lsb));
      if (cpha && ticks >= 1 && ticks < 16)
        chk(mosi_o == bit_of(txb, (ticks-1)/2, lsb), "R6/R7 mosi", mosi_o, bit_of(txb, (ticks-1)/2, lsb));
      chk(irq == (ie && m >= 16*half), "R9 irq", irq, ie && m >= 16*half);
      idx = cpha ? ((ticks >= 1) ? (ticks-1)/2 : 0) : ticks/2;
      if (idx <= 7) miso_i = bit_of(slvb, idx, lsb);
      @(negedge clk);
    end
    if (early_rd) begin
      rd(2'd2, r); chk(r == slvb, "R8 data", r, slvb);
      rd(2'd1, r); chk(r[7] == 1'b1, "R11 flag kept", r, 8'h80);
      chk(irq == ie, "R11 irq kept", irq, ie);
    end
    rd(2'd1, r);
    chk(r == {1'b1, coll_at >= 0, 5'b0, dbl}, "R3/R9/R10 status", r, {1'b1, coll_at >= 0, 5'b0, dbl});
    rd(2'd2, r); chk(r == slvb, "R8 data", r, slvb);
    rd(2'd1, r); chk(r == {7'b0, dbl}, "R11 cleared", r, {7'b0, dbl});
    chk(irq == 1'b0, "R9 irq low", irq, 0);
  endtask

  task automatic slave_xfer(input logic [7:0] ctl, input logic [7:0] txb, input logic [7:0] mb);
    localparam int H = 8;
    logic cpol, cpha, lsb;
    logic [7:0] got, r;
    cpol = ctl[3]; cpha = ctl[2]; lsb = ctl[5];
    got = 0;
    sck_i = cpol;
    wr(2'd0, ctl);
    wr(2'd1, 8'h00);
    cur_dbl = 0;
    wr(2'd2, txb);
    ss_n_i = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = bit_of(mb, i, lsb);
        repeat (H) @(negedge clk);
        if (lsb) got[i] = miso_o; else got[7-i] = miso_o;
        sck_i = ~sck_i;
        repeat (H) @(negedge clk);
        sck_i = ~sck_i;
      end else begin
        sck_i = ~sck_i;
        mosi_i = bit_of(mb, i, lsb);
        repeat (H) @(negedge clk);
        if (lsb) got[i] = miso_o; else got[7-i] = miso_o;
        sck_i = ~sck_i;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    ss_n_i = 1;
    repeat (4) @(negedge clk);
    chk(got == txb, "R12/R6/R7 slave tx", got, txb);
    rd(2'd1, r); chk(r == 8'h80, "R9 slave done", r, 8'h80);
    rd(2'd2, r); chk(r == mb, "R8 slave rx", r, mb);
    rd(2'd1, r); chk(r == 8'h00, "R11 slave clear", r, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nrun++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0 && sck_o == 0 && mosi_o == 0 && miso_o == 0, "R1 outputs", {irq, sck_o, mosi_o, miso_o}, 0);
    rd(2'd0, r); chk(r == 0, "R1 ctrl", r, 0);
    rd(2'd1, r); chk(r == 0, "R1 stat", r, 0);
    rd(2'd2, r); chk(r == 0, "R1 data", r, 0);
    // R2 readback, R3 reserved bits
    wr(2'd0, 8'h8B); rd(2'd0, r); chk(r == 8'h8B, "R2 ctrl", r, 8'h8B);
    wr(2'd1, 8'hFF); rd(2'd1, r); chk(r == 8'h01, "R3 stat", r, 8'h01);
    // master: mode 0 msb /16, select held low (R4 ignore), early data read (R11)
    ss_n_i = 0;
    master_xfer(8'hD1, 1'b0, 8'hA5, 8'h3C, -1, 1'b1);
    ss_n_i = 1;
    // mode 3 lsb, /4 doubled -> /2
    master_xfer(8'h7C, 1'b1, 8'h96, 8'hE1, -1, 1'b0);
    // mode 1 msb /64 with a collision write mid-transfer (R10)
    master_xfer(8'hD6, 1'b0, 8'h5A, 8'hC3, 40, 1'b0);
    // mode 2 lsb /128, then /128 doubled
    master_xfer(8'h7B, 1'b0, 8'h01, 8'h80, -1, 1'b0);
    master_xfer(8'hFB, 1'b1, 8'hF0, 8'h0F, -1, 1'b0);
    // slave modes
    slave_xfer(8'h40, 8'hB4, 8'h2D);
    slave_xfer(8'h6C, 8'h71, 8'hCE);
    // R12: edges while deselected are ignored
    wr(2'd0, 8'h40);
    sck_i = 0; mosi_i = 1;
    for (int k = 0; k < 16; k++) begin
      repeat (6) @(negedge clk);
      sck_i = ~sck_i;
      chk(miso_o == 0, "R12 miso idle", miso_o, 0);
    end
    repeat (6) @(negedge clk);
    rd(2'd1, r); chk(r == 8'h00, "R12 no flag", r, 0);
    rd(2'd2, r); chk(r == 8'hCE, "R12 rx kept", r, 8'hCE);
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule